// File: doc/BRIEF.md
# Masked Associative Lookup Memory

This block is a small associative memory. It stores a set of fixed-width words, each with its own valid bit. A lookup does not read data from an address. Instead, it takes a search value and returns the position of a stored word that holds that value.

Every search carries two vectors of the same width:
- a key, which is the value to look for;
- a care vector, which selects the bit positions that take part in the comparison.

Because of the care vector, any field or group of fields in a word can serve as the lookup key. The rest of the word is ignored.

Each search runs through a short pipeline:
1. The key and care vector are captured into a comparand register and a mask register.
2. The comparand is broadcast to every stored word at once, and each word has its own comparator. Each comparator sets one tag bit, and all tag bits are captured together.
3. A gathering stage reduces the tag bits to a hit flag, a multiple-hit flag and the lowest matching position. It reports these together with a copy of the full tag vector.

A separate write port sets the word and valid bit of an entry, addressed by index. Where an entry sits has no effect on whether it matches.

Top module: `assoc_lookup`

## Requirements
- R1: A write with `wr_en` high at rising edge k stores `wr_word` and `wr_valid` at entry `wr_idx`. A search presented at edge k+1 or later sees that word and valid bit. Writing `wr_valid`=0 removes an entry from matching.
- R2: Entry i matches a search when it is valid and `((word_i ^ key) & care) == 0`. A care bit of 1 compares that position; a care bit of 0 is don't-care.
- R3: A search whose care vector is all zeros matches every valid entry, whatever the key.
- R4: An entry whose valid bit is 0 never matches, even if its stored word equals the key.
- R5: `res_tags` bit i is 1 exactly when entry i matched the search being reported.
- R6: `res_hit` is 1 when at least one tag is set. `res_idx` is the lowest index whose tag is set, and 0 when there is no hit.
- R7: `res_multi` is 1 exactly when two or more tags are set.
- R8: A search presented with `srch_go` high at edge k has its result on the outputs, with `res_valid` high for one cycle, after edge k+2. Searches on consecutive cycles each produce their own result on consecutive cycles.
- R9: A write presented at the same edge as a search does not affect that search.
- R10: After reset every entry is invalid, and `res_valid`, `res_hit`, `res_multi`, `res_idx` and `res_tags` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| srch_go | input | 1 | Start a search this cycle |
| srch_key | input | WIDTH | Value to look for |
| srch_care | input | WIDTH | Care vector: 1 = compare this bit, 0 = don't care |
| wr_en | input | 1 | Write an entry this cycle |
| wr_idx | input | IDXW | Index of the entry to write |
| wr_word | input | WIDTH | Word to store |
| wr_valid | input | 1 | Valid bit to store with the word |
| res_valid | output | 1 | Result outputs hold a new search result |
| res_hit | output | 1 | At least one entry matched |
| res_multi | output | 1 | Two or more entries matched |
| res_idx | output | IDXW | Lowest matching index (0 when no hit) |
| res_tags | output | ENTRIES | Per-entry match bits of the reported search |

## Verification
The matching rule is exercised with four kinds of care vector, each separating a different fault:
- A full care vector tells an exact compare apart from a partial one.
- A care vector covering only the upper byte shows whether don't-care bits are really ignored, and it yields multiple hits.
- An all-zero care vector exposes any dependence on the key.
- Random care vectors mix both behaviours.

Keys are often taken from stored words, and words come from a small pool, so single hits, multiple hits and misses all occur often. That pattern tests the priority order and the multi-hit flag.

Directed cases cover three points. Invalid entries that hold the key test the valid gating. A write in the same cycle as a search, compared with a write one cycle earlier, tests the write-ordering boundary. Back-to-back searches test that results are not mixed up in the pipeline.

// File: rtl/assoc_lookup_pkg.sv
package assoc_lookup_pkg;
    localparam int unsigned DEF_ENTRIES = 16;
    localparam int unsigned DEF_WIDTH   = 16;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/al_store.sv
module al_store #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned WIDTH   = 16,
    parameter int unsigned IDXW    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDXW-1:0]                 wr_idx,
    input  logic [WIDTH-1:0]                wr_word,
    input  logic                            wr_valid,
    output logic [ENTRIES-1:0][WIDTH-1:0]   words_o,
    output logic [ENTRIES-1:0]              vld_o
);
    typedef struct packed {
        logic                           pend_en;
        logic [IDXW-1:0]                pend_idx;
        logic [WIDTH-1:0]               pend_word;
        logic                           pend_vld;
        logic [ENTRIES-1:0][WIDTH-1:0]  mem;
        logic [ENTRIES-1:0]             vld;
    } st_t;

    st_t st_d, st_q;

    // A write is held for one cycle before it is committed, so a search
    // presented at the same edge compares against the old contents.
    always_comb begin
        st_d           = st_q;
        st_d.pend_en   = wr_en;
        st_d.pend_idx  = wr_idx;
        st_d.pend_word = wr_word;
        st_d.pend_vld  = wr_valid;
        if (st_q.pend_en && (int'(st_q.pend_idx) < ENTRIES)) begin
            st_d.mem[st_q.pend_idx] = st_q.pend_word;
            st_d.vld[st_q.pend_idx] = st_q.pend_vld;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words_o = st_q.mem;
    assign vld_o   = st_q.vld;

    // R1
    commit_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend_en |=> (vld_o[$past(st_q.pend_idx)] == $past(st_q.pend_vld)));
endmodule

// File: rtl/al_match.sv
module al_match #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned WIDTH   = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            go,
    input  logic [WIDTH-1:0]                key,
    input  logic [WIDTH-1:0]                care,
    input  logic [ENTRIES-1:0][WIDTH-1:0]   words_i,
    input  logic [ENTRIES-1:0]              vld_i,
    output logic                            tags_v_o,
    output logic [ENTRIES-1:0]              tags_o
);
    typedef struct packed {
        logic                   s1_v;
        logic [WIDTH-1:0]       cmp;
        logic [WIDTH-1:0]       msk;
        logic                   s2_v;
        logic [ENTRIES-1:0]     tags;
    } st_t;

    st_t st_d, st_q;
    logic [ENTRIES-1:0] word_hit;

    // One comparator per stored word, all fed by the broadcast comparand.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
        assign word_hit[i] = vld_i[i] &&
                             (((words_i[i] ^ st_q.cmp) & st_q.msk) == '0);
    end

    always_comb begin
        st_d      = st_q;
        st_d.s1_v = go;
        if (go) begin
            st_d.cmp = key;
            st_d.msk = care;
        end
        st_d.s2_v = st_q.s1_v;
        if (st_q.s1_v) st_d.tags = word_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tags_v_o = st_q.s2_v;
    assign tags_o   = st_q.tags;

    // R4
    invalid_no_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s2_v |-> ((st_q.tags & ~$past(vld_i)) == '0));
endmodule

// File: rtl/al_gather.sv
module al_gather #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned IDXW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tags_v_i,
    input  logic [ENTRIES-1:0]  tags_i,
    output logic                res_valid_o,
    output logic                hit_o,
    output logic                multi_o,
    output logic [IDXW-1:0]     idx_o,
    output logic [ENTRIES-1:0]  tags_o
);
    localparam logic [ENTRIES-1:0] ONE = ENTRIES'(1);

    typedef struct packed {
        logic               rv;
        logic               hit;
        logic               multi;
        logic [IDXW-1:0]    idx;
        logic [ENTRIES-1:0] tags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic found;
        logic second;
        logic [IDXW-1:0] low;
        found  = 1'b0;
        second = 1'b0;
        low    = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (tags_i[i]) begin
                if (found) second = 1'b1;
                else begin
                    found = 1'b1;
                    low   = IDXW'(i);
                end
            end
        end
        st_d    = st_q;
        st_d.rv = tags_v_i;
        if (tags_v_i) begin
            st_d.hit   = found;
            st_d.multi = second;
            st_d.idx   = low;
            st_d.tags  = tags_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid_o = st_q.rv;
    assign hit_o       = st_q.hit;
    assign multi_o     = st_q.multi;
    assign idx_o       = st_q.idx;
    assign tags_o      = st_q.tags;

    // R6
    lowest_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && hit_o) |-> (tags_o[idx_o] &&
            ((tags_o & ((ONE << idx_o) - ONE)) == '0)));

    // R7
    multi_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && multi_o) |-> (hit_o && ($countones(tags_o) > 1)));
endmodule

// File: rtl/assoc_lookup.sv
module assoc_lookup
    import assoc_lookup_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned WIDTH   = DEF_WIDTH,
    localparam int unsigned IDXW   = idx_bits(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                srch_go,
    input  logic [WIDTH-1:0]    srch_key,
    input  logic [WIDTH-1:0]    srch_care,
    input  logic                wr_en,
    input  logic [IDXW-1:0]     wr_idx,
    input  logic [WIDTH-1:0]    wr_word,
    input  logic                wr_valid,
    output logic                res_valid,
    output logic                res_hit,
    output logic                res_multi,
    output logic [IDXW-1:0]     res_idx,
    output logic [ENTRIES-1:0]  res_tags
);
    logic [ENTRIES-1:0][WIDTH-1:0] words;
    logic [ENTRIES-1:0]            vld;
    logic                          tags_v;
    logic [ENTRIES-1:0]            tags;

    al_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDXW(IDXW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .wr_valid(wr_valid),
        .words_o(words), .vld_o(vld)
    );

    al_match #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_match (
        .clk(clk), .rst_n(rst_n), .go(srch_go), .key(srch_key),
        .care(srch_care), .words_i(words), .vld_i(vld),
        .tags_v_o(tags_v), .tags_o(tags)
    );

    al_gather #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_gather (
        .clk(clk), .rst_n(rst_n), .tags_v_i(tags_v), .tags_i(tags),
        .res_valid_o(res_valid), .hit_o(res_hit), .multi_o(res_multi),
        .idx_o(res_idx), .tags_o(res_tags)
    );

    // R8
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(srch_go, 3));
endmodule

// File: tb/assoc_lookup_bench.sv
`timescale 1ns/1ps
module assoc_lookup_bench;
    localparam int N = 16;
    localparam int W = 16;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0, we = 1'b0, wv = 1'b0;
    logic [W-1:0] key = '0, care = '0, wword = '0;
    logic [IW-1:0] widx = '0;
    logic rv, rhit, rmulti;
    logic [IW-1:0] ridx;
    logic [N-1:0] rtags;

    int total = 0, bad = 0;
    bit done = 0;

    logic [W-1:0] mw [N];
    logic         mv [N];

    logic         pv [3];
    logic         ph [3];
    logic         pm [3];
    int           pi [3];
    logic [N-1:0] pt [3];
    string        pr [3];

    always #2.5 clk = ~clk;

    assoc_lookup u_assoc_lookup (
        .clk(clk), .rst_n(rst_n), .srch_go(go), .srch_key(key),
        .srch_care(care), .wr_en(we), .wr_idx(widx), .wr_word(wword),
        .wr_valid(wv), .res_valid(rv), .res_hit(rhit), .res_multi(rmulti),
        .res_idx(ridx), .res_tags(rtags)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] ref_tags(input logic [W-1:0] k, input logic [W-1:0] c);
        logic [N-1:0] t = '0;
        for (int i = 0; i < N; i++)
            t[i] = mv[i] && (((mw[i] ^ k) & c) == '0);
        return t;
    endfunction

    function automatic int ref_low(input logic [N-1:0] t);
        for (int i = 0; i < N; i++) if (t[i]) return i;
        return 0;
    endfunction

    // One cycle: check the result due now, then drive the new inputs and
    // update the model (write applied after the search is evaluated, R9).
    task automatic step(input string tag, input logic g, input logic [W-1:0] k,
                        input logic [W-1:0] c, input logic e, input int ix,
                        input logic [W-1:0] d, input logic v);
        logic [N-1:0] t;
        @(negedge clk);
        chk({"R8 valid ", pr[2]}, longint'(rv), longint'(pv[2]));
        if (pv[2]) begin
            chk({"R5 tags ", pr[2]}, longint'(rtags), longint'(pt[2]));
            chk({"R6 hit ", pr[2]}, longint'(rhit), longint'(ph[2]));
            chk({"R6 idx ", pr[2]}, longint'(ridx), longint'(pi[2]));
            chk({"R7 multi ", pr[2]}, longint'(rmulti), longint'(pm[2]));
        end
        for (int s = 2; s > 0; s--) begin
            pv[s] = pv[s-1]; ph[s] = ph[s-1]; pm[s] = pm[s-1];
            pi[s] = pi[s-1]; pt[s] = pt[s-1]; pr[s] = pr[s-1];
        end
        t = ref_tags(k, c);
        pv[0] = g; pt[0] = t; ph[0] = |t; pm[0] = ($countones(t) > 1);
        pi[0] = ref_low(t); pr[0] = tag;
        go = g; key = k; care = c; we = e; widx = IW'(ix); wword = d; wv = v;
        if (e) begin
            mw[ix] = d;
            mv[ix] = v;
        end
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) step("idle", 0, '0, '0, 0, 0, '0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240617));
        for (int i = 0; i < N; i++) begin mw[i] = '0; mv[i] = 0; end
        for (int s = 0; s < 3; s++) begin
            pv[s] = 0; ph[s] = 0; pm[s] = 0; pi[s] = 0; pt[s] = '0; pr[s] = "";
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 res_valid", longint'(rv), 0);
        chk("R10 res_hit", longint'(rhit), 0);
        chk("R10 res_multi", longint'(rmulti), 0);
        chk("R10 res_idx", longint'(ridx), 0);
        chk("R10 res_tags", longint'(rtags), 0);
        // R10: nothing valid, even a don't-care search misses
        step("R10 empty", 1, 16'h0000, 16'h0000, 0, 0, '0, 0);
        idle(3);
        // R1 writes; entry 2 holds the key but is invalid (R4)
        step("w", 0, '0, '0, 1, 5, 16'hA5C3, 1);
        step("w", 0, '0, '0, 1, 9, 16'hA5FF, 1);
        step("w", 0, '0, '0, 1, 2, 16'hA5C3, 0);
        step("R1 R2 R4 exact", 1, 16'hA5C3, 16'hFFFF, 0, 0, '0, 0);
        step("R2 R7 field", 1, 16'hA500, 16'hFF00, 0, 0, '0, 0);
        step("R3 zero care", 1, 16'h0F0F, 16'h0000, 0, 0, '0, 0);
        // R9 same-cycle write is not seen; next-cycle search sees it (R1)
        step("R9 same cycle", 1, 16'hA5C3, 16'hFFFF, 1, 1, 16'hA5C3, 1);
        step("R1 next cycle", 1, 16'hA5C3, 16'hFFFF, 0, 0, '0, 0);
        step("w", 0, '0, '0, 1, 1, 16'hA5C3, 0);
        step("R1 R4 invalidated", 1, 16'hA5C3, 16'hFFFF, 0, 0, '0, 0);
        step("R2 miss", 1, 16'h1234, 16'hFFFF, 0, 0, '0, 0);
        idle(3);
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] k, c, d;
            int r;
            d = W'(($urandom % 6) * 16'h1111) ^ W'($urandom % 4);
            r = int'($urandom % 4);
            c = (r == 0) ? 16'h0000 : (r == 1) ? 16'hFFFF : W'($urandom);
            k = ($urandom % 2) ? mw[$urandom % N] : W'(($urandom % 6) * 16'h1111);
            step("rand", ($urandom % 3) != 0, k, c, ($urandom % 2) == 1,
                 int'($urandom % N), d, ($urandom % 5) != 0);
        end
        idle(4);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule